// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is a single DMA channel with a small register window and a sequencer that walks descriptor chains in memory. Software loads the source address, destination address, byte count, link pointer and control word through a word-addressed register port, then sets the enable bit. The channel moves data one beat at a time over a simple memory port. Each beat is a read of the source followed by a write of the returned word to the destination. Beats are grouped into bursts, and before each burst the channel needs either the software-request bit or a peripheral request.

When the byte count reaches zero, a nonzero link pointer makes the channel read a nine-word descriptor at that address and carry on. A zero link ends the chain. A link that points back at the same descriptor repeats the transfer for ever, until software aborts it. Clearing enable pauses the channel at the next beat boundary, and setting it again resumes from the same position. A control write with the close bit set and enable clear aborts the channel at once. A one-cycle interrupt marks the end of each descriptor whose interrupt-enable bits are set.

Top module: `lldma_channel`

## Requirements
- R1: After reset, `busy`, `irq` and `mem_req` are low and every register reads zero.
- R2: The register port decodes `reg_addr[5:2]`. Word offsets are: 0x00 source, 0x04 destination, 0x08 count (16 bits), 0x1C link, 0x20 control. These read back what was written. Offsets 0x0C, 0x10 and 0x14 (the 2-D stepping words) always read zero.
- R3: Each beat reads the source address and then writes the returned word to the destination address. The beat size in bytes is 1 << W, where W is the source width field in control bits 8:6 (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). The count drops by the beat size, except that the last beat takes whatever remains, so a count C gives ceil(C / beat size) beats. The descriptor ends when the count reaches zero.
- R4: After each beat the source address advances by the source beat size unless control bit 2 (fixed source) is set. The destination address advances by the destination beat size, taken from control bits 15:13, unless control bit 3 (fixed destination) is set.
- R5: A burst is at most (control bits 12:9) + 1 beats. If control bit 1 (software request) is set, bursts run back to back. If it is clear, each burst starts only after `periph_req` is seen high while the channel waits between bursts.
- R6: Writing control with bit 0 clear while `busy` is high pauses the channel after the current beat, and no memory writes occur while it is paused. Writing bit 0 set resumes the transfer with no beat skipped or repeated.
- R7: A control write with bit 31 set and bit 0 clear drops `busy` at the next edge. After that no memory request and no interrupt occurs.
- R8: When the count reaches zero and the link is nonzero, the channel reads nine words at link + 4*i for i = 0..8, in that order. It loads source (i = 0), destination (1), count (2), link (7) and control (8), discards words 3 to 6, and continues. When the link is zero, the chain ends and `busy` falls.
- R9: A descriptor whose link word holds its own address repeats its transfer without end, and the link register reads that address while the channel runs.
- R10: `irq` pulses for one cycle at the end of a descriptor only when control bits 5:4 are nonzero.
- R11: `busy` rises only after a control write with bit 0 set. It stays high until the chain ends or the channel is aborted, and `mem_req` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset in the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| periph_req | input | 1 | Peripheral request that starts a burst when software request is off |
| mem_req | output | 1 | Memory access request, one cycle per access |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Channel owns a transfer or chain |
| irq | output | 1 | One-cycle end-of-descriptor interrupt |

## Verification
The bench builds the block with its default 32-bit addresses and a 16-bit count. This lets it place source, destination and descriptor areas in one 1 KiB memory model, whose data is a pure function of the address. With that setup the bench sweeps every beat width against all four fixed-address combinations and against counts that divide exactly and counts that leave a remainder. It also runs a gated-burst case, a pause, an abort, a three-descriptor chain whose reserved words are filled with junk, and a self-linked cyclic descriptor.

// File: rtl/lldma_pkg.sv
`timescale 1ns/1ps
package lldma_pkg;

    localparam int WORD_W = 32;

    // Register word offsets (reg_addr[5:2]); descriptor words use the same order
    localparam logic [3:0] OFF_SRC   = 4'd0;
    localparam logic [3:0] OFF_DST   = 4'd1;
    localparam logic [3:0] OFF_CNT   = 4'd2;
    localparam logic [3:0] OFF_ZY    = 4'd3;
    localparam logic [3:0] OFF_SSTEP = 4'd4;
    localparam logic [3:0] OFF_DSTEP = 4'd5;
    localparam logic [3:0] OFF_LINK  = 4'd7;
    localparam logic [3:0] OFF_CTRL  = 4'd8;

    typedef struct packed {
        logic        fclose;
        logic [14:0] rsvd;
        logic [2:0]  dwidth;
        logic [3:0]  blen_m1;
        logic [2:0]  swidth;
        logic [1:0]  irq_en;
        logic        dfix;
        logic        sfix;
        logic        swreq;
        logic        en;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD, ST_RWAIT, ST_WR, ST_END, ST_FETCH, ST_FWAIT
    } seq_st_t;

    function automatic logic [3:0] beat_bytes(input logic [2:0] w);
        case (w)
            3'd0:    return 4'd1;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/lldma_regs.sv
`timescale 1ns/1ps
module lldma_regs
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              ld_we,
    input  logic [3:0]        ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              upd_we,
    input  logic [ADDR_W-1:0] upd_src,
    input  logic [ADDR_W-1:0] upd_dst,
    input  logic [CNT_W-1:0]  upd_cnt,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] link_q,
    output ctrl_t             ctrl_q,
    output logic              start_p,
    output logic              abort_p
);

    logic [3:0] widx;
    logic       ctrl_wr;
    logic       unused_ok;

    assign widx      = reg_addr[5:2];
    assign ctrl_wr   = reg_we && (widx == OFF_CTRL);
    assign start_p   = ctrl_wr && reg_wdata[0];
    assign abort_p   = ctrl_wr && reg_wdata[31] && !reg_wdata[0];
    assign unused_ok = ^reg_addr[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            link_q <= '0;
            ctrl_q <= '0;
        end else if (ld_we) begin
            case (ld_idx)
                OFF_SRC:  src_q  <= ADDR_W'(ld_data);
                OFF_DST:  dst_q  <= ADDR_W'(ld_data);
                OFF_CNT:  cnt_q  <= CNT_W'(ld_data);
                OFF_LINK: link_q <= ADDR_W'(ld_data);
                OFF_CTRL: ctrl_q <= ctrl_t'(ld_data);
                default: ;
            endcase
        end else begin
            if (reg_we) begin
                case (widx)
                    OFF_SRC:  src_q  <= ADDR_W'(reg_wdata);
                    OFF_DST:  dst_q  <= ADDR_W'(reg_wdata);
                    OFF_CNT:  cnt_q  <= CNT_W'(reg_wdata);
                    OFF_LINK: link_q <= ADDR_W'(reg_wdata);
                    OFF_CTRL: ctrl_q <= ctrl_t'(reg_wdata);
                    default: ;
                endcase
            end
            if (upd_we) begin
                src_q <= upd_src;
                dst_q <= upd_dst;
                cnt_q <= upd_cnt;
            end
        end
    end

    always_comb begin
        case (widx)
            OFF_SRC:  reg_rdata = WORD_W'(src_q);
            OFF_DST:  reg_rdata = WORD_W'(dst_q);
            OFF_CNT:  reg_rdata = WORD_W'(cnt_q);
            OFF_LINK: reg_rdata = WORD_W'(link_q);
            OFF_CTRL: reg_rdata = ctrl_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/lldma_seq.sv
`timescale 1ns/1ps
module lldma_seq
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] src_q,
    input  logic [ADDR_W-1:0] dst_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [ADDR_W-1:0] link_q,
    input  ctrl_t             ctrl_q,
    input  logic              start_p,
    input  logic              abort_p,
    input  logic              periph_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ld_we,
    output logic [3:0]        ld_idx,
    output logic [WORD_W-1:0] ld_data,
    output logic              upd_we,
    output logic [ADDR_W-1:0] upd_src,
    output logic [ADDR_W-1:0] upd_dst,
    output logic [CNT_W-1:0]  upd_cnt,
    output logic              busy,
    output logic              irq
);

    seq_st_t           st_q;
    logic              busy_q;
    logic [3:0]        beat_q;
    logic [3:0]        fidx_q;
    logic [ADDR_W-1:0] fbase_q;
    logic [WORD_W-1:0] data_q;

    logic [3:0]        sb, db;
    logic [CNT_W-1:0]  take;
    logic              go;
    logic              unused_ok;

    assign unused_ok = ^{ctrl_q.fclose, ctrl_q.rsvd};

    assign sb      = beat_bytes(ctrl_q.swidth);
    assign db      = beat_bytes(ctrl_q.dwidth);
    assign take    = (cnt_q < CNT_W'(sb)) ? cnt_q : CNT_W'(sb);
    assign upd_cnt = cnt_q - take;
    assign upd_src = ctrl_q.sfix ? src_q : src_q + ADDR_W'(sb);
    assign upd_dst = ctrl_q.dfix ? dst_q : dst_q + ADDR_W'(db);
    assign go      = ctrl_q.swreq || periph_req;

    assign mem_req   = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_FETCH);
    assign mem_we    = (st_q == ST_WR);
    assign mem_wdata = data_q;
    assign upd_we    = (st_q == ST_WR);
    assign ld_we     = (st_q == ST_FWAIT) && mem_rvalid;
    assign ld_idx    = fidx_q;
    assign ld_data   = mem_rdata;
    assign irq       = (st_q == ST_END) && (|ctrl_q.irq_en);
    assign busy      = busy_q;

    always_comb begin
        case (st_q)
            ST_RD:    mem_addr = src_q;
            ST_WR:    mem_addr = dst_q;
            ST_FETCH: mem_addr = fbase_q + ADDR_W'({fidx_q, 2'b00});
            default:  mem_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            busy_q  <= 1'b0;
            beat_q  <= '0;
            fidx_q  <= '0;
            fbase_q <= '0;
            data_q  <= '0;
        end else if (abort_p) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (!busy_q) begin
                        if (start_p) busy_q <= 1'b1;
                    end else if (ctrl_q.en) begin
                        if (cnt_q == '0) begin
                            st_q <= ST_END;
                        end else if (go) begin
                            beat_q <= '0;
                            st_q   <= ST_RD;
                        end
                    end
                end
                ST_RD:    st_q <= ST_RWAIT;
                ST_RWAIT: begin
                    if (mem_rvalid) begin
                        data_q <= mem_rdata;
                        st_q   <= ST_WR;
                    end
                end
                ST_WR: begin
                    beat_q <= beat_q + 4'd1;
                    if (upd_cnt == '0)
                        st_q <= ST_END;
                    else if ((beat_q == ctrl_q.blen_m1) || !ctrl_q.en)
                        st_q <= ST_IDLE;
                    else
                        st_q <= ST_RD;
                end
                ST_END: begin
                    if (link_q != '0) begin
                        fbase_q <= link_q;
                        fidx_q  <= '0;
                        st_q    <= ST_FETCH;
                    end else begin
                        busy_q <= 1'b0;
                        st_q   <= ST_IDLE;
                    end
                end
                ST_FETCH: st_q <= ST_FWAIT;
                ST_FWAIT: begin
                    if (mem_rvalid) begin
                        if (fidx_q == OFF_CTRL) begin
                            st_q <= ST_IDLE;
                        end else begin
                            fidx_q <= fidx_q + 4'd1;
                            st_q   <= ST_FETCH;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lldma_channel.sv
`timescale 1ns/1ps
module lldma_channel
    import lldma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              periph_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              irq
);

    logic [ADDR_W-1:0] src_q, dst_q, link_q;
    logic [CNT_W-1:0]  cnt_q;
    ctrl_t             ctrl_q;
    logic              start_p, abort_p;
    logic              ld_we, upd_we;
    logic [3:0]        ld_idx;
    logic [WORD_W-1:0] ld_data;
    logic [ADDR_W-1:0] upd_src, upd_dst;
    logic [CNT_W-1:0]  upd_cnt;

    lldma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .upd_we(upd_we), .upd_src(upd_src), .upd_dst(upd_dst), .upd_cnt(upd_cnt),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .link_q(link_q), .ctrl_q(ctrl_q),
        .start_p(start_p), .abort_p(abort_p)
    );

    lldma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .link_q(link_q), .ctrl_q(ctrl_q),
        .start_p(start_p), .abort_p(abort_p), .periph_req(periph_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .upd_we(upd_we), .upd_src(upd_src), .upd_dst(upd_dst), .upd_cnt(upd_cnt),
        .busy(busy), .irq(irq)
    );

endmodule

// File: rtl/lldma_channel_chk.sv
`timescale 1ns/1ps
module lldma_channel_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        mem_req,
    input logic        busy,
    input logic        irq
);

    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr[5:2] == 4'd8);

    assert_req_busy_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy) else $error("memory request while idle");

    assert_start_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(ctrl_wr && reg_wdata[0])) else $error("busy rose without enable write");

    assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[31] && !reg_wdata[0]) |=> (!busy && !irq)) else $error("abort not honoured");

    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) else $error("interrupt longer than one cycle");

    assert_irq_busy_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> busy) else $error("interrupt outside a transfer");

endmodule

bind lldma_channel lldma_channel_chk u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .busy(busy), .irq(irq)
);

// File: tb/tb_lldma_channel.sv
`timescale 1ns/1ps
module tb_lldma_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, irq;

    always #2.5 clk = ~clk;

    lldma_channel dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .periph_req(periph_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .busy(busy), .irq(irq)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [31:0] dmem [0:63];
    logic [31:0] wa [0:63];
    logic [31:0] wd [0:63];
    int wn = 0, irqn = 0;
    logic clr_log = 1'b0;

    function automatic logic [31:0] mdata(input logic [31:0] a);
        if (a[31:8] == 24'h3) return dmem[a[7:2]];
        return a ^ 32'h5A5A_0000;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= mem_req && !mem_we && !rst;
        mem_rdata  <= mdata(mem_addr);
        if (clr_log) begin
            wn <= 0; irqn <= 0;
        end else begin
            if (mem_req && mem_we) begin
                if (wn < 64) begin wa[wn] <= mem_addr; wd[wn] <= mem_wdata; end
                wn <= wn + 1;
            end
            if (irq) irqn <= irqn + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic clear_log();
        @(negedge clk); clr_log = 1'b1;
        @(negedge clk); clr_log = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c,
                        input logic [31:0] l);
        wr(6'h00, s); wr(6'h04, d); wr(6'h08, c); wr(6'h1C, l);
    endtask

    function automatic int cnt_of(input int ci);
        case (ci)
            0: return 1;
            1: return 3;
            2: return 8;
            default: return 13;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n1;
        for (int i = 0; i < 64; i++) dmem[i] = 32'hDEAD_0000 | i;
        // chain: 0x300 -> 0x340 -> end ; cyclic at 0x380
        dmem[0] = 32'h40;  dmem[1] = 32'h240; dmem[2] = 32'd12; dmem[7] = 32'h340; dmem[8] = 32'h4693;
        dmem[16] = 32'h80; dmem[17] = 32'h280; dmem[18] = 32'd4; dmem[23] = 32'h0; dmem[24] = 32'h4693;
        dmem[32] = 32'h10; dmem[33] = 32'h210; dmem[34] = 32'd8; dmem[39] = 32'h380; dmem[40] = 32'h4693;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 mem_req", {31'b0, mem_req}, 0);
        for (int a = 0; a < 9; a++) begin
            rd(6'(a * 4), v); chk("R1 register zero", v, 0);
        end

        // R2 register map and zeroed 2-D words
        load(32'h1234, 32'h5678, 32'h12345, 32'h11C0);
        wr(6'h0C, 32'hFFFF_FFFF); wr(6'h10, 32'h1111); wr(6'h14, 32'h2222);
        wr(6'h20, 32'h0000_4680);
        rd(6'h00, v); chk("R2 source", v, 32'h1234);
        rd(6'h04, v); chk("R2 destination", v, 32'h5678);
        rd(6'h08, v); chk("R2 count 16 bits", v, 32'h2345);
        rd(6'h1C, v); chk("R2 link", v, 32'h11C0);
        rd(6'h20, v); chk("R2 control", v, 32'h4680);
        rd(6'h0C, v); chk("R2 zy count zero", v, 0);
        rd(6'h10, v); chk("R2 src step zero", v, 0);
        rd(6'h14, v); chk("R2 dst step zero", v, 0);
        chk("R2 no start without enable", {31'b0, busy}, 0);
        wr(6'h20, 32'h0);

        // R3 R4 R10 sweep: widths x fixed modes x counts
        for (int w = 0; w < 4; w++) begin
            for (int fm = 0; fm < 4; fm++) begin
                for (int ci = 0; ci < 4; ci++) begin
                    int c, bytes, nb;
                    logic [31:0] ctl, ea, er;
                    c = cnt_of(ci);
                    bytes = 1 << w;
                    nb = (c + bytes - 1) / bytes;
                    ctl = 32'h3 | (32'(fm) << 2) | 32'h10 | (32'(w) << 6) | (32'h3 << 9) | (32'(w) << 13);
                    clear_log();
                    load(32'h40, 32'h200, 32'(c), 32'h0);
                    wr(6'h20, ctl);
                    wait_idle();
                    chk("R3 beat count", 32'(wn), 32'(nb));
                    for (int k = 0; k < nb && k < 64; k++) begin
                        ea = fm[1] ? 32'h200 : 32'h200 + 32'(k * bytes);
                        er = fm[0] ? 32'h40 : 32'h40 + 32'(k * bytes);
                        chk("R4 destination address", wa[k], ea);
                        chk("R3 data moved", wd[k], mdata(er));
                    end
                    chk("R10 one irq", 32'(irqn), 1);
                    chk("R11 busy low at end", {31'b0, busy}, 0);
                    rd(6'h08, v); chk("R3 count reaches zero", v, 0);
                    rd(6'h00, v);
                    chk("R4 final source", v, fm[0] ? 32'h40 : 32'h40 + 32'(nb * bytes));
                end
            end
        end

        // R5 peripheral-gated bursts of 4 beats, 10 beats in total
        clear_log();
        load(32'h0, 32'h200, 32'd40, 32'h0);
        wr(6'h20, 32'h4681);
        repeat (20) @(negedge clk);
        chk("R5 no burst without request", 32'(wn), 0);
        chk("R11 busy while waiting", {31'b0, busy}, 1);
        for (int p = 1; p <= 3; p++) begin
            @(negedge clk); periph_req = 1'b1;
            @(negedge clk); periph_req = 1'b0;
            repeat (40) @(negedge clk);
            chk("R5 beats after request", 32'(wn), (p == 3) ? 32'd10 : 32'(4 * p));
        end
        chk("R5 done after last burst", {31'b0, busy}, 0);
        chk("R10 no irq when disabled", 32'(irqn), 0);

        // R6 pause and resume
        clear_log();
        load(32'h0, 32'h200, 32'd64, 32'h0);
        wr(6'h20, 32'h4093);
        repeat (10) @(negedge clk);
        wr(6'h20, 32'h4092);
        repeat (5) @(negedge clk);
        n1 = wn;
        repeat (30) @(negedge clk);
        chk("R6 no writes while paused", 32'(wn), 32'(n1));
        chk("R6 busy held while paused", {31'b0, busy}, 1);
        chk("R6 paused before end", {31'(n1 < 16)}, 1);
        wr(6'h20, 32'h4093);
        wait_idle();
        chk("R6 total beats after resume", 32'(wn), 16);
        for (int k = 0; k < 16; k++) chk("R6 no skip or repeat", wa[k], 32'h200 + 32'(4 * k));
        chk("R6 irq once", 32'(irqn), 1);

        // R7 abort
        clear_log();
        load(32'h0, 32'h200, 32'd64, 32'h0);
        wr(6'h20, 32'h5E93);
        repeat (12) @(negedge clk);
        wr(6'h20, 32'h8000_0000);
        chk("R7 busy low after abort", {31'b0, busy}, 0);
        n1 = wn;
        repeat (30) @(negedge clk);
        chk("R7 no writes after abort", 32'(wn), 32'(n1));
        chk("R7 no irq", 32'(irqn), 0);
        chk("R7 stopped early", {31'(n1 < 16)}, 1);

        // R8 chain of three descriptors
        clear_log();
        load(32'h0, 32'h200, 32'd8, 32'h300);
        wr(6'h20, 32'h4683);
        wait_idle();
        chk("R8 total beats", 32'(wn), 6);
        chk("R8 beat0", wa[0], 32'h200); chk("R8 data0", wd[0], mdata(32'h0));
        chk("R8 beat1", wa[1], 32'h204); chk("R8 data1", wd[1], mdata(32'h4));
        chk("R8 beat2", wa[2], 32'h240); chk("R8 data2", wd[2], mdata(32'h40));
        chk("R8 beat4", wa[4], 32'h248); chk("R8 data4", wd[4], mdata(32'h48));
        chk("R8 beat5", wa[5], 32'h280); chk("R8 data5", wd[5], mdata(32'h80));
        chk("R10 irq only for enabled descriptors", 32'(irqn), 2);
        rd(6'h1C, v); chk("R8 zero link at end", v, 0);
        rd(6'h00, v); chk("R8 source from last descriptor", v, 32'h84);
        rd(6'h0C, v); chk("R2 junk reserved word not visible", v, 0);

        // R9 cyclic self-linked descriptor
        clear_log();
        load(32'h0, 32'h0, 32'd0, 32'h380);
        wr(6'h20, 32'h4683);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irqn >= 3) break;
        end
        chk("R9 repeated completions", {31'b0, irqn >= 3}, 1);
        chk("R9 still busy", {31'b0, busy}, 1);
        rd(6'h1C, v); chk("R9 link reads loop address", v, 32'h380);
        wr(6'h20, 32'h8000_0000);
        chk("R7 abort ends cyclic run", {31'b0, busy}, 0);
        for (int k = 0; k < 6; k++) begin
            chk("R9 repeating address", wa[k], (k % 2) ? 32'h214 : 32'h210);
            chk("R9 repeating data", wd[k], mdata((k % 2) ? 32'h14 : 32'h10));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule